// File: doc/BRIEF.md
# Tanh Soft-Clipping Waveshaper

This block shapes a mono audio stream with a smooth saturating curve. Each signed 16-bit Q1.15 sample is multiplied by a programmable Q2.14 drive gain. The product is brought back to Q1.15 and clamped so that it cannot wrap. The magnitude of the result then addresses a single-sided table holding a tanh-like curve, and the sign of the scaled value is put back on the table output. Because only the positive half is stored and the sign is restored, the curve is odd-symmetric by construction, and silence stays silence.

Samples arrive and leave on valid/ready/data stream ports. A small write-only register port sets an enable bit and the drive gain. When enable is low, samples take a plain delay path whose length matches the shaping path, so switching modes never shifts the stream in time. The latency is fixed at five register stages: four in the shaping core and one output alignment register. Both control values are captured together with each sample, so a register write takes effect on the first sample accepted after the write.

Top module: `tanh_shaper`

## Requirements
- R1: After synchronous reset, out_valid is 0, in_ready is 1, enable is 0 (bypass) and the drive gain is 0x4000 (unity in Q2.14).
- R2: A write with cfg_wr_addr = 0 sets enable from cfg_wr_data[0]; a write with cfg_wr_addr = 1 sets the drive gain from cfg_wr_data[15:0]; writes to addresses 2 and 3 change nothing.
- R3: The scaled value is the signed product sample × drive divided by 2^14 with truncation toward zero, then saturated to [-32768, 32767]; it never wraps.
- R4: The magnitude of the scaled value is its absolute value, with -32768 clamped to 32767; the table index is magnitude bits [14:7].
- R5: Table entry i equals round(32767 · u(27·N² + u²) / (N(27·N² + 9u²))) with u = 3i and N = 256, capped at 32767, which is a rational tanh approximation over the input range 0 to 3; entry 0 is 0.
- R6: With enable high, out_data is the table entry when the scaled value is non-negative and its two's complement negation otherwise, so f(-x) = -f(x) and a zero sample gives exactly zero.
- R7: A sample accepted at a rising edge appears on out_data with out_valid high after the fifth rising edge counted from and including the accepting edge, independent of its value.
- R8: With enable low, out_data equals the input sample unchanged, with the same latency as R7.
- R9: in_ready is high exactly when out_ready is high or out_valid is low; while out_valid is high and out_ready low, out_valid and out_data hold, and no sample is lost or repeated.
- R10: Enable and drive are captured with each sample at its accepting edge; a write in the same cycle as an acceptance applies only to later samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 2 | Register address (0 mode, 1 drive) |
| cfg_wr_data | input | 16 | Register write data |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| in_data | input | 16 | Input sample, signed Q1.15 |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 16 | Output sample, signed Q1.15 |

## Verification
The bench drives the full-scale corners: maximum drive on both extreme samples, where a missing clamp would wrap a loud sample to the opposite polarity, and the most negative sample at unity, where a naive absolute value overflows back to -32768 and reads the wrong table end. Mirrored sample pairs and a zero sample expose a one-LSB asymmetry in the divide or a sign applied to a zero result. A write landing in the same cycle as an accepted sample catches control that is sampled a cycle early or late, and long output stalls catch a pipeline that slips, drops or duplicates samples while the enable bit toggles between the two paths.

// File: rtl/tanh_shaper_pkg.sv
package tanh_shaper_pkg;

    localparam int SAMPLE_W    = 16;
    localparam int DRIVE_W     = 16;
    localparam int DRIVE_FRAC  = 14;
    localparam int LUT_IDX_W   = 8;
    localparam int CURVE_SPAN  = 3;
    localparam int CFG_ADDR_W  = 2;
    localparam int CFG_DATA_W  = 16;

    localparam int MAG_W       = SAMPLE_W - 1;
    localparam int PROD_W      = SAMPLE_W + DRIVE_W;
    localparam int LUT_DEPTH   = 1 << LUT_IDX_W;
    localparam int IDX_SHIFT   = MAG_W - LUT_IDX_W;

    localparam logic [CFG_ADDR_W-1:0] ADDR_MODE  = CFG_ADDR_W'(0);
    localparam logic [CFG_ADDR_W-1:0] ADDR_DRIVE = CFG_ADDR_W'(1);

    localparam logic signed [DRIVE_W-1:0] DRIVE_UNITY = DRIVE_W'(1 << DRIVE_FRAC);

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [DRIVE_W-1:0]  drive_t;
    typedef logic        [MAG_W-1:0]    mag_t;
    typedef logic        [LUT_IDX_W-1:0] idx_t;

    localparam sample_t SAMPLE_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam sample_t SAMPLE_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};
    localparam mag_t    MAG_MAX    = {MAG_W{1'b1}};

    // Side information that travels with every sample through the stages.
    typedef struct packed {
        logic    en;
        sample_t raw;
    } tag_t;

    // Scale by drive, divide by 2^DRIVE_FRAC rounding toward zero, saturate.
    function automatic sample_t scale_sat(input sample_t s, input drive_t d);
        logic signed [PROD_W-1:0] p;
        logic signed [PROD_W-1:0] q;
        logic signed [PROD_W-1:0] bias;
        logic signed [PROD_W-1:0] hi;
        logic signed [PROD_W-1:0] lo;
        bias = PROD_W'((1 << DRIVE_FRAC) - 1);
        hi   = PROD_W'(SAMPLE_MAX);
        lo   = -hi - PROD_W'(1);
        p    = PROD_W'(s) * PROD_W'(d);
        if (p < 0)
            q = (p + bias) >>> DRIVE_FRAC;
        else
            q = p >>> DRIVE_FRAC;
        if (q > hi)
            return SAMPLE_MAX;
        else if (q < lo)
            return SAMPLE_MIN;
        else
            return SAMPLE_W'(q);
    endfunction

    // Absolute value with the most negative code clamped to full scale.
    function automatic mag_t fold_mag(input sample_t v);
        if (v == SAMPLE_MIN)
            return MAG_MAX;
        else if (v < 0)
            return MAG_W'(-v);
        else
            return MAG_W'(v);
    endfunction

    // Rational tanh approximation, evaluated once per table entry.
    function automatic mag_t tanh_entry(input int idx);
        longint n;
        longint u;
        longint a;
        longint num;
        longint den;
        longint r;
        n   = longint'(LUT_DEPTH);
        u   = longint'(CURVE_SPAN) * longint'(idx);
        a   = 27 * n * n;
        num = longint'(MAG_MAX) * u * (a + u * u);
        den = n * (a + 9 * u * u);
        r   = (num + den / 2) / den;
        if (r > longint'(MAG_MAX))
            r = longint'(MAG_MAX);
        return MAG_W'(r);
    endfunction

endpackage

// File: rtl/ts_cfg_regs.sv
module ts_cfg_regs
    import tanh_shaper_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [CFG_ADDR_W-1:0] wr_addr,
    input  logic [CFG_DATA_W-1:0] wr_data,
    output logic                  enable,
    output drive_t                drive
);

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= 1'b0;
            drive  <= DRIVE_UNITY;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_MODE:  enable <= wr_data[0];
                ADDR_DRIVE: drive  <= drive_t'(wr_data[DRIVE_W-1:0]);
                default:    ;
            endcase
        end
    end

    // R2: without a write strobe the settings do not move
    a_r2_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(enable) && $stable(drive));

    // R2: unmapped addresses leave both settings untouched
    a_r2_unmapped_ignored: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_addr != ADDR_MODE && wr_addr != ADDR_DRIVE
            |=> $stable(enable) && $stable(drive));

endmodule

// File: rtl/ts_curve_lut.sv
module ts_curve_lut
    import tanh_shaper_pkg::*;
(
    input  idx_t idx,
    output mag_t level
);

    mag_t table_w [LUT_DEPTH];

    for (genvar g = 0; g < LUT_DEPTH; g++) begin : g_entry
        localparam mag_t ENTRY = tanh_entry(g);
        assign table_w[g] = ENTRY;
    end

    assign level = table_w[idx];

endmodule

// File: rtl/ts_shape_core.sv
module ts_shape_core
    import tanh_shaper_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    adv,
    input  logic    in_fire,
    input  sample_t in_sample,
    input  logic    enable,
    input  drive_t  drive,
    output logic    st4_valid,
    output sample_t st4_shaped,
    output tag_t    st4_tag
);

    // Stage 1: drive scaling with saturation
    logic    v1;
    sample_t scaled1;
    tag_t    tag1;
    // Stage 2: magnitude fold and sign capture
    logic    v2;
    idx_t    idx2;
    logic    neg2;
    tag_t    tag2;
    // Stage 3: table lookup
    logic    v3;
    mag_t    level3;
    logic    neg3;
    tag_t    tag3;

    mag_t    level_w;
    mag_t    mag_w;

    assign mag_w = fold_mag(scaled1);

    ts_curve_lut u_lut (
        .idx   (idx2),
        .level (level_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            v1        <= 1'b0;
            v2        <= 1'b0;
            v3        <= 1'b0;
            st4_valid <= 1'b0;
        end else if (adv) begin
            v1        <= in_fire;
            v2        <= v1;
            v3        <= v2;
            st4_valid <= v3;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scaled1    <= '0;
            tag1       <= '0;
            idx2       <= '0;
            neg2       <= 1'b0;
            tag2       <= '0;
            level3     <= '0;
            neg3       <= 1'b0;
            tag3       <= '0;
            st4_shaped <= '0;
            st4_tag    <= '0;
        end else if (adv) begin
            scaled1    <= scale_sat(in_sample, drive);
            tag1       <= '{en: enable, raw: in_sample};
            idx2       <= LUT_IDX_W'(mag_w >> IDX_SHIFT);
            neg2       <= scaled1[SAMPLE_W-1];
            tag2       <= tag1;
            level3     <= level_w;
            neg3       <= neg2;
            tag3       <= tag2;
            st4_shaped <= neg3 ? -sample_t'({1'b0, level3}) : sample_t'({1'b0, level3});
            st4_tag    <= tag3;
        end
    end

    // R3: a positive sample with positive drive never wraps to a negative value
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        adv && in_fire && in_sample > 0 && drive > 0 |=> !scaled1[SAMPLE_W-1]);

    // R5: the lowest index reads back as zero
    a_r5_zero_entry: assert property (@(posedge clk) disable iff (rst)
        adv && v2 && idx2 == '0 |=> level3 == '0);

    // R6: the reapplied sign follows the captured sign unless the result is zero
    a_r6_sign_restore: assert property (@(posedge clk) disable iff (rst)
        adv && v3 |=> st4_shaped == '0 || st4_shaped[SAMPLE_W-1] == $past(neg3));

    // R7: a valid sample moves one stage per advancing edge
    a_r7_valid_shift: assert property (@(posedge clk) disable iff (rst)
        adv && v3 |=> st4_valid);

endmodule

// File: rtl/tanh_shaper.sv
module tanh_shaper
    import tanh_shaper_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_wr_en,
    input  logic [CFG_ADDR_W-1:0] cfg_wr_addr,
    input  logic [CFG_DATA_W-1:0] cfg_wr_data,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [SAMPLE_W-1:0]   in_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [SAMPLE_W-1:0]   out_data
);

    logic    enable;
    drive_t  drive;
    logic    adv;
    logic    st4_valid;
    sample_t st4_shaped;
    tag_t    st4_tag;

    assign adv      = out_ready || !out_valid;
    assign in_ready = adv;

    ts_cfg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_wr_addr),
        .wr_data (cfg_wr_data),
        .enable  (enable),
        .drive   (drive)
    );

    ts_shape_core u_core (
        .clk        (clk),
        .rst        (rst),
        .adv        (adv),
        .in_fire    (in_valid && adv),
        .in_sample  (sample_t'(in_data)),
        .enable     (enable),
        .drive      (drive),
        .st4_valid  (st4_valid),
        .st4_shaped (st4_shaped),
        .st4_tag    (st4_tag)
    );

    // Output alignment stage; bypass samples ride the same four stages.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (adv) begin
            out_valid <= st4_valid;
            out_data  <= st4_tag.en ? st4_shaped : st4_tag.raw;
        end
    end

    // R9: a stalled output holds its value
    a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R8: bypassed samples leave unchanged
    a_r8_bypass_raw: assert property (@(posedge clk) disable iff (rst)
        adv && st4_valid && !st4_tag.en |=> out_data == $past(st4_tag.raw));

    // R6: shaped samples leave as the core computed them
    a_r6_shaped_out: assert property (@(posedge clk) disable iff (rst)
        adv && st4_valid && st4_tag.en |=> out_data == $past(st4_shaped));

endmodule

// File: tb/test_tanh_shaper.sv
module test_tanh_shaper;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_wr_addr = '0;
    logic [15:0] cfg_wr_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_data;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    bit          m_en = 0;
    logic [15:0] m_drv = 16'h4000;
    int          exp_q[$];
    string       tag_q[$];
    string       cur_tag = "R1";

    always #2.5 clk = ~clk;

    tanh_shaper i_tanh_shaper (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_addr (cfg_wr_addr),
        .cfg_wr_data (cfg_wr_data),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_data     (in_data),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_data    (out_data)
    );

    function automatic int curve(int i);
        longint u = 3 * i;
        longint a = 1769472;
        longint num = 32767 * u * (a + u * u);
        longint den = 256 * (a + 9 * u * u);
        longint r = (2 * num + den) / (2 * den);
        if (r > 32767) r = 32767;
        return int'(r);
    endfunction

    function automatic int model(logic [15:0] s, logic [15:0] d, bit en);
        longint p;
        longint q;
        longint mag;
        int y;
        if (!en) return int'($signed(s));
        p = longint'($signed(s)) * longint'($signed(d));
        q = p / 16384;
        if (q > 32767) q = 32767;
        if (q < -32768) q = -32768;
        mag = (q < 0) ? -q : q;
        if (mag > 32767) mag = 32767;
        y = curve(int'(mag / 128));
        return (q < 0) ? -y : y;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // One cycle: drive at the falling edge, settle, then account for the
    // transfers that the next rising edge will perform.
    task automatic step(bit iv, logic [15:0] d, bit ordy, bit wr, logic [1:0] addr, logic [15:0] wd);
        @(negedge clk);
        in_valid = iv; in_data = d; out_ready = ordy;
        cfg_wr_en = wr; cfg_wr_addr = addr; cfg_wr_data = wd;
        #1;
        if (in_valid && in_ready) begin
            exp_q.push_back(model(d, m_drv, m_en));
            tag_q.push_back(cur_tag);
        end
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(0, "R9 unexpected output", int'($signed(out_data)), 0);
            end else begin
                int e = exp_q.pop_front();
                string t = tag_q.pop_front();
                check(int'($signed(out_data)) == e, t, int'($signed(out_data)), e);
            end
        end
        if (wr) begin
            if (addr == 2'd0) m_en = wd[0];
            else if (addr == 2'd1) m_drv = wd;
        end
    endtask

    task automatic wr(logic [1:0] addr, logic [15:0] wd);
        step(0, '0, 1, 1, addr, wd);
    endtask

    task automatic send(logic [15:0] d);
        step(1, d, 1, 0, '0, '0);
    endtask

    task automatic drain();
        for (int i = 0; i < 40 && exp_q.size() != 0; i++) step(0, '0, 1, 0, '0, '0);
        step(0, '0, 1, 0, '0, '0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                check(0, "watchdog", cycles, 100000);
                finish_run();
            end
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

        // R1 R8: default is bypass
        cur_tag = "R1 R8 default bypass";
        send(16'h03E8); send(16'h8000); send(16'h7FFF);
        drain();

        // R1 R6: default drive is unity
        wr(2'd0, 16'h0001);
        cur_tag = "R1 R6 unity drive";
        send(16'd10000); send(-16'sd10000);
        drain();

        // R7: latency count
        cur_tag = "R7 latency value";
        send(16'd20000);
        for (int i = 1; i <= 5; i++) begin
            step(0, '0, 1, 0, '0, '0);
            check(out_valid == (i == 5), "R7 latency", int'(out_valid), int'(i == 5));
        end
        drain();

        // R3: saturation at maximum drive
        wr(2'd1, 16'h7FFF);
        cur_tag = "R3 saturation";
        send(16'h7FFF); send(16'h8000); send(16'd3000); send(-16'sd3000);
        drain();

        // R4: most negative sample at unity
        wr(2'd1, 16'h4000);
        cur_tag = "R4 min clamp";
        send(16'h8000); send(16'h0080); send(16'h007F);
        drain();

        // R6: zero and mirrored pairs
        cur_tag = "R6 symmetry";
        send(16'h0000); send(16'd12345); send(-16'sd12345); send(16'd1); send(-16'sd1);
        drain();

        // R5: walk the table edges
        cur_tag = "R5 table";
        for (int i = 0; i < 256; i += 17) send(16'(i * 128));
        send(16'h7F80);
        drain();

        // R2: unmapped writes ignored, observed through later samples
        wr(2'd2, 16'h0000); wr(2'd3, 16'h0000);
        cur_tag = "R2 unmapped ignored";
        send(16'd16000); send(-16'sd7000);
        drain();
        wr(2'd1, 16'hC000);
        cur_tag = "R2 negative drive";
        send(16'd16000);
        drain();

        // R10: write in the same cycle as an accepted sample
        cur_tag = "R10 same-cycle write";
        step(1, 16'd9000, 1, 1, 2'd1, 16'h2000);
        send(16'd9000);
        step(1, 16'd9000, 1, 1, 2'd0, 16'h0000);
        send(16'd9000);
        drain();

        // R9: stall holds output and blocks input
        wr(2'd0, 16'h0001);
        cur_tag = "R9 stall";
        for (int i = 0; i < 8; i++) step(1, 16'(i * 3001), 0, 0, '0, '0);
        begin
            logic [15:0] held = out_data;
            for (int i = 0; i < 3; i++) begin
                step(1, 16'd555, 0, 0, '0, '0);
                check(out_valid && out_data == held, "R9 hold", int'(out_data), int'(held));
                check(in_ready == 1'b0, "R9 in_ready", int'(in_ready), 0);
            end
        end
        drain();

        // Random traffic with config writes
        cur_tag = "R9 R10 random";
        for (int i = 0; i < 3000; i++) begin
            bit iv = ($urandom % 4) != 0;
            bit ordy = ($urandom % 3) != 0;
            bit w = ($urandom % 20) == 0;
            logic [1:0] a = 2'($urandom % 4);
            logic [15:0] d = 16'($urandom);
            if (($urandom % 10) == 0) d = (($urandom % 2) != 0) ? 16'h8000 : 16'h7FFF;
            step(iv, d, ordy, w, a, 16'($urandom));
        end
        drain();
        check(exp_q.size() == 0, "R9 no loss", exp_q.size(), 0);

        finish_run();
    end

endmodule